// File: doc/BRIEF.md
# PHY Link Status Poller

This block keeps an up-to-date view of an Ethernet PHY's link condition without software involvement. Each time a poll-interval tick arrives while nothing is outstanding, it asks an attached management-bus master to read the PHY's status summary register. It then waits for the master to finish and decodes the returned word into four fields: link state, autonegotiation completion, resolved speed and duplex mode.

The master starts a transaction on the rising edge of its read request. For this reason the poller raises the request and holds it until it sees the master's busy flag high, and only then drops it. When busy falls again, the poller inspects the master's no-acknowledge flag. A read that was not acknowledged leaves the previously decoded status untouched and sets an error output that stays set until reset. A read that succeeds updates the status. If any decoded field differs from the value held before, a one-cycle change strobe marks the update.

Top module: `phy_link_poller`

## Requirements
- R1: After reset, `mst_rd_req`, `link_up`, `an_done`, `full_duplex`, `stat_chg` and `rd_err` are 0, and `speed` is 2'b11 (unknown).
- R2: A `poll_tick` seen while idle raises `mst_rd_req` in the next cycle. `mst_reg_addr` is 5'h19. `mst_phy_addr` holds the `phy_addr` value sampled with that tick, even if `phy_addr` changes later.
- R3: `mst_rd_req` stays high for as long as `mst_busy` is low, and falls in the cycle after `mst_busy` is first seen high.
- R4: A `poll_tick` that arrives while a request is pending or the master is busy is ignored and does not start another read.
- R5: On the cycle where `mst_busy` is seen low after being seen high, with `mst_rd_fail` low, the read word is captured. `link_up` takes bit 2 and `an_done` takes bit 15. No other bit outside 10:8 has any effect.
- R6: Bits 10:8 of the word give `speed` (2'b00 = 10 Mb/s, 2'b01 = 100 Mb/s, 2'b10 = 1000 Mb/s) and `full_duplex`. The mapping is: 001 → 10 half, 010 → 10 full, 100 → 100 half, 101 → 100 full, 110 → 1000 half, 111 → 1000 full.
- R7: Codes 000 and 011 are reserved. They give `speed` = 2'b11 and `full_duplex` = 0.
- R8: A completion with `mst_rd_fail` high leaves `link_up`, `an_done`, `speed` and `full_duplex` unchanged and produces no `stat_chg`.
- R9: A failed read sets `rd_err`, which then stays high until reset, including through later successful reads.
- R10: `stat_chg` pulses for exactly one cycle, together with the status update, when a successful read changes any decoded field. It stays low when the decoded value is the same as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_tick | input | 1 | One-cycle pulse asking for a new status read |
| phy_addr | input | 5 | Address of the PHY to poll |
| mst_rd_req | output | 1 | Read request to the management master (edge-started) |
| mst_phy_addr | output | 5 | PHY address presented to the master |
| mst_reg_addr | output | 5 | Register address presented to the master |
| mst_busy | input | 1 | Master transaction in progress |
| mst_rd_data | input | 16 | Word returned by the master |
| mst_rd_fail | input | 1 | Master saw no acknowledge from the PHY |
| link_up | output | 1 | Link established |
| an_done | output | 1 | Autonegotiation complete |
| speed | output | 2 | Resolved speed: 00 = 10, 01 = 100, 10 = 1000, 11 = unknown |
| full_duplex | output | 1 | Full duplex resolved |
| stat_chg | output | 1 | One-cycle pulse when decoded status changed |
| rd_err | output | 1 | Sticky flag: a read was not acknowledged |

## Verification
Returned words are chosen to walk through every speed/duplex code, including both reserved ones. The check for each code looks at `speed` and `full_duplex` on their own, so the link and negotiation bits cannot mask a decode error. Some reads repeat the previous word, which separates a real change from a spurious strobe. Other reads set every unrelated bit and clear the decoded ones, which shows that only bits 2, 15 and 10:8 matter. Failed reads are placed between reads that would change the status, so that a capture on failure shows up as a changed output and a cleared error as a falling `rd_err`. Ticks arrive both while the request is pending and while the master is busy, and the request line is then watched for a second rising edge.

// File: rtl/phy_poll_pkg.sv
package phy_poll_pkg;

    typedef enum logic [1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_UNK  = 2'b11
    } speed_e;

    typedef struct packed {
        logic   link;
        logic   an_done;
        speed_e speed;
        logic   full_dup;
    } phy_stat_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_REQ  = 2'b01,
        SQ_WAIT = 2'b10
    } seq_st_e;

    localparam phy_stat_t STAT_RST = '{link: 1'b0, an_done: 1'b0,
                                       speed: SPD_UNK, full_dup: 1'b0};

    // Resolve the 3-bit speed/duplex code; reserved codes report unknown.
    function automatic phy_stat_t build_stat(input logic lnk, input logic an,
                                             input logic [2:0] code);
        phy_stat_t s;
        s.link    = lnk;
        s.an_done = an;
        case (code)
            3'b001:  begin s.speed = SPD_10;   s.full_dup = 1'b0; end
            3'b010:  begin s.speed = SPD_10;   s.full_dup = 1'b1; end
            3'b100:  begin s.speed = SPD_100;  s.full_dup = 1'b0; end
            3'b101:  begin s.speed = SPD_100;  s.full_dup = 1'b1; end
            3'b110:  begin s.speed = SPD_1000; s.full_dup = 1'b0; end
            3'b111:  begin s.speed = SPD_1000; s.full_dup = 1'b1; end
            default: begin s.speed = SPD_UNK;  s.full_dup = 1'b0; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/phy_poll_seq.sv
// Request sequencer: launches a read on a tick, holds the request until the
// master reports busy, then flags completion when busy drops.
module phy_poll_seq
    import phy_poll_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_tick,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mst_busy,
    output logic              rd_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              done
);

    typedef struct packed {
        seq_st_e           st;
        logic              req;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: SQ_IDLE, req: 1'b0, addr: '0};

    seq_t seq_d, seq_q;
    logic done_d;

    always_comb begin
        seq_d  = seq_q;
        done_d = 1'b0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (poll_tick) begin
                    seq_d.st   = SQ_REQ;
                    seq_d.req  = 1'b1;
                    seq_d.addr = phy_addr;
                end
            end
            SQ_REQ: begin
                if (mst_busy) begin
                    seq_d.st  = SQ_WAIT;
                    seq_d.req = 1'b0;
                end
            end
            SQ_WAIT: begin
                if (!mst_busy) begin
                    seq_d.st = SQ_IDLE;
                    done_d   = 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign rd_req   = seq_q.req;
    assign req_addr = seq_q.addr;
    assign done     = done_d;

endmodule

// File: rtl/phy_poll_decode.sv
// Status capture: decodes a completed read, keeps the old status on a
// failed read, raises the sticky error and the change strobe.
module phy_poll_decode
    import phy_poll_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int LINK_BIT = 2,
    parameter int AN_BIT   = 15,
    parameter int SD_LSB   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              rd_fail,
    input  logic [DATA_W-1:0] rd_data,
    output phy_stat_t         stat,
    output logic              chg,
    output logic              err
);

    localparam int SD_W = 3;

    typedef struct packed {
        phy_stat_t stat;
        logic      chg;
        logic      err;
    } dec_t;

    localparam dec_t DEC_RST = '{stat: STAT_RST, chg: 1'b0, err: 1'b0};

    dec_t      dec_d, dec_q;
    phy_stat_t fresh;
    logic      unused_word;

    assign unused_word = ^rd_data;
    assign fresh = build_stat(rd_data[LINK_BIT], rd_data[AN_BIT],
                              rd_data[SD_LSB +: SD_W]);

    always_comb begin
        dec_d     = dec_q;
        dec_d.chg = 1'b0;
        if (done) begin
            if (rd_fail) begin
                dec_d.err = 1'b1;
            end else begin
                dec_d.stat = fresh;
                dec_d.chg  = (fresh != dec_q.stat);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= DEC_RST;
        else        dec_q <= dec_d;
    end

    assign stat = dec_q.stat;
    assign chg  = dec_q.chg;
    assign err  = dec_q.err;

endmodule

// File: rtl/phy_link_poller.sv
module phy_link_poller
    import phy_poll_pkg::*;
#(
    parameter int              ADDR_W   = 5,
    parameter int              DATA_W   = 16,
    parameter logic [ADDR_W-1:0] STAT_REG = 5'h19,
    parameter int              LINK_BIT = 2,
    parameter int              AN_BIT   = 15,
    parameter int              SD_LSB   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_tick,
    input  logic [ADDR_W-1:0] phy_addr,
    output logic              mst_rd_req,
    output logic [ADDR_W-1:0] mst_phy_addr,
    output logic [ADDR_W-1:0] mst_reg_addr,
    input  logic              mst_busy,
    input  logic [DATA_W-1:0] mst_rd_data,
    input  logic              mst_rd_fail,
    output logic              link_up,
    output logic              an_done,
    output logic [1:0]        speed,
    output logic              full_duplex,
    output logic              stat_chg,
    output logic              rd_err
);

    logic      rd_done;
    phy_stat_t cur_stat;

    phy_poll_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .poll_tick(poll_tick),
        .phy_addr (phy_addr),
        .mst_busy (mst_busy),
        .rd_req   (mst_rd_req),
        .req_addr (mst_phy_addr),
        .done     (rd_done)
    );

    phy_poll_decode #(
        .DATA_W  (DATA_W),
        .LINK_BIT(LINK_BIT),
        .AN_BIT  (AN_BIT),
        .SD_LSB  (SD_LSB)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (rd_done),
        .rd_fail(mst_rd_fail),
        .rd_data(mst_rd_data),
        .stat   (cur_stat),
        .chg    (stat_chg),
        .err    (rd_err)
    );

    assign mst_reg_addr = STAT_REG;
    assign link_up      = cur_stat.link;
    assign an_done      = cur_stat.an_done;
    assign speed        = cur_stat.speed;
    assign full_duplex  = cur_stat.full_dup;

endmodule

// File: rtl/phy_link_poller_chk.sv
module phy_link_poller_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       poll_tick,
    input logic       mst_busy,
    input logic       mst_rd_req,
    input logic       link_up,
    input logic       an_done,
    input logic [1:0] speed,
    input logic       full_duplex,
    input logic       stat_chg,
    input logic       rd_err
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_rd_req && !mst_busy) |=> mst_rd_req);

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_rd_req) |-> $past(mst_busy));

    // R2
    req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_rd_req) |-> $past(poll_tick));

    // R10
    chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_chg |=> !stat_chg);

    // R10
    stat_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({link_up, an_done, speed, full_duplex}) |-> stat_chg);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> rd_err);

endmodule

bind phy_link_poller phy_link_poller_chk u_chk (.*);

// File: tb/phy_link_poller_test.sv
module phy_link_poller_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        poll_tick;
    logic [4:0]  phy_addr;
    logic        mst_rd_req;
    logic [4:0]  mst_phy_addr;
    logic [4:0]  mst_reg_addr;
    logic        mst_busy;
    logic [15:0] mst_rd_data;
    logic        mst_rd_fail;
    logic        link_up, an_done, full_duplex, stat_chg, rd_err;
    logic [1:0]  speed;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    phy_link_poller uut (
        .clk(clk), .rst_n(rst_n), .poll_tick(poll_tick), .phy_addr(phy_addr),
        .mst_rd_req(mst_rd_req), .mst_phy_addr(mst_phy_addr),
        .mst_reg_addr(mst_reg_addr), .mst_busy(mst_busy),
        .mst_rd_data(mst_rd_data), .mst_rd_fail(mst_rd_fail),
        .link_up(link_up), .an_done(an_done), .speed(speed),
        .full_duplex(full_duplex), .stat_chg(stat_chg), .rd_err(rd_err)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // {data[15:0], fail, link, an, speed[1:0], fdx, chg, err}
    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        {16'h8504, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0},
        {16'h8504, 1'b0, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0},
        {16'h0000, 1'b1, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1},
        {16'h0000, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
        {16'h8704, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1},
        {16'h8604, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1},
        {16'h8104, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1},
        {16'h8204, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1},
        {16'h8404, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1},
        {16'h8304, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
        {16'h7BFB, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
        {16'h0004, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
        {16'h8000, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1}
    };

    // One full read: tick, request, master handshake, completion.
    task automatic run_poll(input logic [15:0] data, input logic fail,
                            input logic [4:0] addr, input bit extra_ticks);
        @(negedge clk);
        phy_addr  = addr;
        poll_tick = 1'b1;
        @(negedge clk);
        poll_tick = 1'b0;
        phy_addr  = ~addr;
        check("R2", "request raised", 32'(mst_rd_req), 32'h1);
        check("R2", "register address", 32'(mst_reg_addr), 32'h19);
        check("R2", "phy address latched", 32'(mst_phy_addr), 32'(addr));
        for (int i = 0; i < 3; i++) begin
            poll_tick = extra_ticks && (i == 1);
            @(negedge clk);
            check("R3", "request held while busy low", 32'(mst_rd_req), 32'h1);
        end
        poll_tick = 1'b0;
        mst_busy  = 1'b1;
        @(negedge clk);
        check("R3", "request dropped after busy", 32'(mst_rd_req), 32'h0);
        poll_tick = extra_ticks;
        @(negedge clk);
        poll_tick   = 1'b0;
        mst_rd_data = data;
        mst_rd_fail = fail;
        @(negedge clk);
        mst_busy = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        poll_tick   = 1'b0;
        phy_addr    = 5'd0;
        mst_busy    = 1'b0;
        mst_rd_data = 16'h0;
        mst_rd_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "mst_rd_req", 32'(mst_rd_req), 32'h0);
        check("R1", "link_up", 32'(link_up), 32'h0);
        check("R1", "an_done", 32'(an_done), 32'h0);
        check("R1", "speed", 32'(speed), 32'h3);
        check("R1", "full_duplex", 32'(full_duplex), 32'h0);
        check("R1", "stat_chg", 32'(stat_chg), 32'h0);
        check("R1", "rd_err", 32'(rd_err), 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            string       sd;
            e  = VEC[v];
            sd = (e[4:3] == 2'b11) ? "R7" : "R6";
            run_poll(e[23:8], e[7], 5'(v + 3), 1'b0);
            check(e[7] ? "R8" : "R5", "link_up", 32'(link_up), 32'(e[6]));
            check(e[7] ? "R8" : "R5", "an_done", 32'(an_done), 32'(e[5]));
            check(e[7] ? "R8" : sd, "speed", 32'(speed), 32'(e[4:3]));
            check(e[7] ? "R8" : sd, "full_duplex", 32'(full_duplex), 32'(e[2]));
            check(e[7] ? "R8" : "R10", "stat_chg", 32'(stat_chg), 32'(e[1]));
            check("R9", "rd_err", 32'(rd_err), 32'(e[0]));
            @(negedge clk);
            check("R10", "stat_chg one cycle", 32'(stat_chg), 32'h0);
        end

        // R4: ticks while request pending and while busy start nothing new
        run_poll(16'h8504, 1'b0, 5'h1F, 1'b1);
        check("R6", "speed after tick test", 32'(speed), 32'h1);
        repeat (4) begin
            @(negedge clk);
            check("R4", "no extra request", 32'(mst_rd_req), 32'h0);
        end

        // R9: error stays through reads, clears only on reset
        check("R9", "rd_err still set", 32'(rd_err), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_err after reset", 32'(rd_err), 32'h0);
        check("R1", "speed after reset", 32'(speed), 32'h3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule